// File: doc/BRIEF.md
# Two-Wire Debug Port Host Controller

This block is the host side of a two-wire debug port. It drives a debug clock line and the target's active-low reset line, and it shares one bidirectional data line with the target. On request it performs the debug-entry sequence. The target's reset is pulled low, two clock pulses are issued, and reset is released. The low period is kept short, because a long one would make the target perform a real reset.

Outside entry the block runs one transaction per request. It shifts out a command of one to four bytes, releases the data line for a turnaround gap, and then clocks one response byte back from the target. Typical commands are a single status query byte (0x34) or an execute-instruction byte (0x56) followed by up to three opcode bytes, such as 0x56 0x90 hi lo to load the data pointer. A surrounding sequencer chains such transactions to read memory.

The request side is a start strobe with a mode bit, a byte count and a packed command word. The block answers with busy, a one-cycle done pulse, a reject pulse and the response byte. The debug clock half-period is a parameterised number of system clocks.

Top module: `twd_host`

## Requirements
- R1: Out of reset the target reset line is high, the debug clock is low, the data output enable is low, and busy, done and reject are low.
- R2: A start with `req_enter`=1 drives the target reset low and produces exactly two rising edges of the debug clock while it is low. It then releases reset and pulses done, with no data-line activity.
- R3: During entry the target reset stays low for exactly (ENTRY_HOLD_HALVES+4)*HALF_CYC system clocks, and never longer.
- R4: A start with `req_enter`=0 and a count N of 1 to 4 shifts out N*8 bits, one per debug clock rising edge. Byte `req_cmd[7:0]` goes first, then `req_cmd[15:8]`, and so on, each byte most-significant bit first.
- R5: The data output changes only while the debug clock is low, and it is stable across every high phase.
- R6: After the last command bit the output enable drops, and at least 2*HALF_CYC system clocks pass before the first read rising edge of the debug clock.
- R7: The read phase gives exactly 8 rising edges, sampling `dd_in` at each rising edge, most-significant bit first. The assembled byte appears on `rsp_byte` in the cycle where done is high.
- R8: The output enable is high only during the command phase. It rises only while the debug clock is low and the target reset is high.
- R9: A start while busy is ignored: the running transaction completes with its own command and count.
- R10: Done is high for exactly one cycle per request. `rsp_byte` changes only in a cycle where done is high after a transaction, and an entry request leaves it unchanged.
- R11: A start with `req_enter`=0 and a count of 0 or greater than 4 pulses `req_reject` one cycle later. Busy stays low and no line changes.
- R12: Busy is high from the cycle after an accepted start until the cycle in which done is high, where it is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| req_start | input | 1 | Start strobe, sampled when idle |
| req_enter | input | 1 | 1: perform debug entry; 0: perform a command transaction |
| req_len | input | LEN_W | Number of command bytes (1 to MAX_BYTES) |
| req_cmd | input | MAX_BYTES*8 | Command bytes, lowest byte sent first |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| req_reject | output | 1 | One-cycle pulse for an invalid byte count |
| rsp_byte | output | 8 | Last response byte received |
| dbg_clk | output | 1 | Debug clock line |
| dbg_rst_n | output | 1 | Target reset line, active low |
| dd_out | output | 1 | Data line output value |
| dd_oe | output | 1 | Data line output enable |
| dd_in | input | 1 | Data line input value |

## Verification
Several properties are checked by the assertions on every cycle. The data output holds steady while the clock is high, and the enable never rises except at a clock-low write start. The reset-low span stays bounded, with exactly two clock rises counted per entry. Done lasts a single cycle, the response register moves only on done, and a reject leaves every line quiet. Other behaviour shows only in the bench's scenarios, which drive a modelled target. These cover the order and count of shifted command bits across every byte count, and the assembled response over all 256 values. They also cover the exact reset-low duration and the dropped start issued during a transfer.

// File: rtl/twd_pkg.sv
package twd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENT_HOLD,
      ST_ENT_PULSE,
      ST_WRITE,
      ST_TURN,
      ST_READ,
      ST_TAIL
   } twd_state_e;

   typedef struct packed {
      logic rst_n;
      logic dc;
      logic oe;
   } twd_lines_t;

   // Line levels for a phase; odd_half is the low bit of the half-period index.
   function automatic twd_lines_t twd_decode(twd_state_e st, logic odd_half);
      twd_lines_t l;
      l = '{rst_n: 1'b1, dc: 1'b0, oe: 1'b0};
      case (st)
         ST_ENT_HOLD:  l = '{rst_n: 1'b0, dc: 1'b0,      oe: 1'b0};
         ST_ENT_PULSE: l = '{rst_n: 1'b0, dc: ~odd_half, oe: 1'b0};
         ST_WRITE:     l = '{rst_n: 1'b1, dc: odd_half,  oe: 1'b1};
         ST_READ:      l = '{rst_n: 1'b1, dc: odd_half,  oe: 1'b0};
         default:      l = '{rst_n: 1'b1, dc: 1'b0,      oe: 1'b0};
      endcase
      return l;
   endfunction

endpackage

// File: rtl/twd_tick_gen.sv
module twd_tick_gen #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic tick
);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("twd_tick_gen: HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_every
      assign tick = active;
   end else begin : g_count
      localparam int CNT_W = $clog2(HALF_CYC);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!active || cnt_q == CNT_LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = active && (cnt_q == CNT_LAST);
   end

endmodule

// File: rtl/twd_cmd_buf.sv
module twd_cmd_buf #(
   parameter int MAX_BYTES = 4,
   localparam int CMD_W = MAX_BYTES * 8,
   localparam int IDX_W = $clog2(CMD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic [IDX_W-1:0] bit_idx,
   output logic             bit_out
);

   logic [CMD_W-1:0] cmd_q;
   logic [CMD_W-1:0] src;
   logic [CMD_W-1:0] stream;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (load) begin
         cmd_q <= cmd_in;
      end
   end

   // Bypass so the first bit is available on the accepting edge.
   assign src = load ? cmd_in : cmd_q;

   // Serial order: byte 0 first, each byte most-significant bit first.
   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign stream[b*8 + k] = src[b*8 + 7 - k];
      end
   end

   assign bit_out = stream[bit_idx];

endmodule

// File: rtl/twd_rsp_shift.sv
module twd_rsp_shift #(
   parameter int RSP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift_en,
   input  logic             din,
   output logic [RSP_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
      end else if (clear) begin
         data <= '0;
      end else if (shift_en) begin
         data <= {data[RSP_W-2:0], din};
      end
   end

endmodule

// File: rtl/twd_host.sv
module twd_host
   import twd_pkg::*;
#(
   parameter int HALF_CYC          = 4,
   parameter int ENTRY_HOLD_HALVES = 2,
   parameter int MAX_BYTES         = 4,
   localparam int LEN_W = $clog2(MAX_BYTES + 1),
   localparam int CMD_W = MAX_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start,
   input  logic             req_enter,
   input  logic [LEN_W-1:0] req_len,
   input  logic [CMD_W-1:0] req_cmd,
   output logic             busy,
   output logic             done,
   output logic             req_reject,
   output logic [7:0]       rsp_byte,
   output logic             dbg_clk,
   output logic             dbg_rst_n,
   output logic             dd_out,
   output logic             dd_oe,
   input  logic             dd_in
);

   localparam int RSP_W      = 8;
   localparam int WR_HALVES  = MAX_BYTES * 16;
   localparam int RD_HALVES  = RSP_W * 2;
   localparam int MAX_A      = (WR_HALVES > RD_HALVES) ? WR_HALVES : RD_HALVES;
   localparam int MAX_HALVES = (MAX_A > ENTRY_HOLD_HALVES) ? MAX_A : ENTRY_HOLD_HALVES;
   localparam int STEP_W     = $clog2(MAX_HALVES + 1);
   localparam int IDX_W      = $clog2(CMD_W);

   localparam logic [STEP_W-1:0] LAST_HOLD  = STEP_W'(ENTRY_HOLD_HALVES - 1);
   localparam logic [STEP_W-1:0] LAST_PULSE = STEP_W'(3);
   localparam logic [STEP_W-1:0] LAST_TURN  = STEP_W'(1);
   localparam logic [STEP_W-1:0] LAST_READ  = STEP_W'(RD_HALVES - 1);

   if (MAX_BYTES < 1 || MAX_BYTES > 8) begin : g_bad_bytes
      $error("twd_host: MAX_BYTES must lie in 1..8");
   end
   if (ENTRY_HOLD_HALVES < 1) begin : g_bad_hold
      $error("twd_host: ENTRY_HOLD_HALVES must be at least 1");
   end

   twd_state_e        st_q, st_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic [LEN_W-1:0]  len_q;
   logic [STEP_W-1:0] last_step;
   logic              tick;
   logic              len_ok;
   logic              accept_tx;
   logic              accept_ent;
   logic              bad_req;
   logic              finish;
   logic              sample;
   logic              cmd_bit;
   logic [IDX_W-1:0]  bit_idx;
   logic [RSP_W-1:0]  shift_data;
   twd_lines_t        lines_d;

   // ---------------- request decode ----------------
   assign len_ok     = (req_len != '0) && (req_len <= LEN_W'(MAX_BYTES));
   assign accept_ent = (st_q == ST_IDLE) && req_start && req_enter;
   assign accept_tx  = (st_q == ST_IDLE) && req_start && !req_enter && len_ok;
   assign bad_req    = (st_q == ST_IDLE) && req_start && !req_enter && !len_ok;

   // ---------------- half-period pacing ----------------
   twd_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (st_q != ST_IDLE),
      .tick   (tick)
   );

   always_comb begin
      case (st_q)
         ST_ENT_HOLD:  last_step = LAST_HOLD;
         ST_ENT_PULSE: last_step = LAST_PULSE;
         ST_WRITE:     last_step = (STEP_W'(len_q) << 4) - STEP_W'(1);
         ST_TURN:      last_step = LAST_TURN;
         ST_READ:      last_step = LAST_READ;
         default:      last_step = '0;
      endcase
   end

   // ---------------- phase sequencing ----------------
   always_comb begin
      st_d   = st_q;
      step_d = step_q;
      finish = 1'b0;
      if (st_q == ST_IDLE) begin
         step_d = '0;
         if (accept_ent) begin
            st_d = ST_ENT_HOLD;
         end else if (accept_tx) begin
            st_d = ST_WRITE;
         end
      end else if (tick) begin
         if (step_q == last_step) begin
            step_d = '0;
            case (st_q)
               ST_ENT_HOLD:  st_d = ST_ENT_PULSE;
               ST_ENT_PULSE: begin st_d = ST_IDLE; finish = 1'b1; end
               ST_WRITE:     st_d = ST_TURN;
               ST_TURN:      st_d = ST_READ;
               ST_READ:      st_d = ST_TAIL;
               default:      begin st_d = ST_IDLE; finish = 1'b1; end
            endcase
         end else begin
            step_d = step_q + 1'b1;
         end
      end
   end

   // Read sampling coincides with the edge that raises the debug clock.
   assign sample  = (st_q == ST_READ) && tick && !step_q[0];
   assign lines_d = twd_decode(st_d, step_d[0]);
   assign bit_idx = IDX_W'(step_d >> 1);

   twd_cmd_buf #(.MAX_BYTES(MAX_BYTES)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept_tx),
      .cmd_in  (req_cmd),
      .bit_idx (bit_idx),
      .bit_out (cmd_bit)
   );

   twd_rsp_shift #(.RSP_W(RSP_W)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept_tx),
      .shift_en (sample),
      .din      (dd_in),
      .data     (shift_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= '0;
         len_q  <= '0;
      end else begin
         st_q   <= st_d;
         step_q <= step_d;
         if (accept_tx) begin
            len_q <= req_len;
         end
      end
   end

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_clk    <= 1'b0;
         dbg_rst_n  <= 1'b1;
         dd_oe      <= 1'b0;
         dd_out     <= 1'b0;
         done       <= 1'b0;
         req_reject <= 1'b0;
         rsp_byte   <= '0;
      end else begin
         dbg_clk    <= lines_d.dc;
         dbg_rst_n  <= lines_d.rst_n;
         dd_oe      <= lines_d.oe;
         dd_out     <= (st_d == ST_WRITE) ? cmd_bit : 1'b0;
         done       <= finish;
         req_reject <= bad_req;
         if (finish && st_q == ST_TAIL) begin
            rsp_byte <= shift_data;
         end
      end
   end

   assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/twd_host_chk.sv
module twd_host_chk #(
   parameter int HALF_CYC          = 4,
   parameter int ENTRY_HOLD_HALVES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       req_reject,
   input logic [7:0] rsp_byte,
   input logic       dbg_clk,
   input logic       dbg_rst_n,
   input logic       dd_out,
   input logic       dd_oe
);

   localparam int LOW_LIMIT = (ENTRY_HOLD_HALVES + 4) * HALF_CYC;
   localparam int LOW_W     = $clog2(LOW_LIMIT + 2) + 1;
   localparam int GAP_MIN   = 2 * HALF_CYC;
   localparam int GAP_W     = $clog2(GAP_MIN + 1) + 1;

   logic             dc_prev;
   logic [2:0]       ent_rises;
   logic [LOW_W-1:0] low_cnt;
   logic [GAP_W-1:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dc_prev   <= 1'b0;
         ent_rises <= '0;
         low_cnt   <= '0;
         gap_cnt   <= '0;
      end else begin
         dc_prev <= dbg_clk;
         if (dbg_rst_n) begin
            ent_rises <= '0;
            low_cnt   <= '0;
         end else begin
            if (dbg_clk && !dc_prev && ent_rises != 3'd7) ent_rises <= ent_rises + 1'b1;
            if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
         end
         if (dd_oe) begin
            gap_cnt <= '0;
         end else if (gap_cnt < GAP_W'(GAP_MIN)) begin
            gap_cnt <= gap_cnt + 1'b1;
         end
      end
   end

   p_entry_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_rst_n) |-> (ent_rises == 3'd2));

   p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LOW_W'(LOW_LIMIT));

   p_dd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_clk |-> $stable(dd_out));

   p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dbg_clk) && !dd_oe && dbg_rst_n) |-> (gap_cnt >= GAP_W'(GAP_MIN)));

   p_oe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dd_oe) |-> (busy && !dbg_clk && dbg_rst_n));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_byte) |-> done);

   p_reject_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> (!busy && dbg_rst_n && !dd_oe && !dbg_clk));

   p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind twd_host twd_host_chk #(
   .HALF_CYC          (HALF_CYC),
   .ENTRY_HOLD_HALVES (ENTRY_HOLD_HALVES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .req_reject (req_reject),
   .rsp_byte   (rsp_byte),
   .dbg_clk    (dbg_clk),
   .dbg_rst_n  (dbg_rst_n),
   .dd_out     (dd_out),
   .dd_oe      (dd_oe)
);

// File: tb/twd_host_test.sv
`timescale 1ns/1ps
module twd_host_test;

   localparam int HALF = 2;
   localparam int HOLD = 2;
   localparam int NB   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic        req_enter = 1'b0;
   logic [2:0]  req_len = '0;
   logic [31:0] req_cmd = '0;
   logic        busy, done, req_reject;
   logic [7:0]  rsp_byte;
   logic        dbg_clk, dbg_rst_n, dd_out, dd_oe;
   logic        dd_in;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // target model state
   logic [7:0]  tgt_rsp = 8'h00;
   logic [31:0] wr_shift = '0;
   int wr_bits = 0, rd_rises = 0, rd_falls = 0, ent_rises = 0, low_cyc = 0;
   int oe_low = 0, first_gap = -1, dc_hi_changes = 0;
   logic prev_dd = 1'b0;

   twd_host #(.HALF_CYC(HALF), .ENTRY_HOLD_HALVES(HOLD), .MAX_BYTES(NB)) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_enter(req_enter),
      .req_len(req_len), .req_cmd(req_cmd), .busy(busy), .done(done),
      .req_reject(req_reject), .rsp_byte(rsp_byte), .dbg_clk(dbg_clk),
      .dbg_rst_n(dbg_rst_n), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in)
   );

   always #5 clk = ~clk;

   assign dd_in = (rd_falls < 8) ? tgt_rsp[7 - rd_falls] : 1'b0;

   always @(posedge clk) begin
      cyc++;
      if (!dbg_rst_n) low_cyc++;
      if (dd_oe) oe_low = 0; else oe_low++;
      if (dbg_clk && dd_out != prev_dd) dc_hi_changes++;
      prev_dd = dd_out;
   end

   always @(posedge dbg_clk) begin
      if (!dbg_rst_n) begin
         ent_rises++;
      end else if (dd_oe) begin
         wr_shift = {wr_shift[30:0], dd_out};
         wr_bits++;
      end else begin
         if (rd_rises == 0) first_gap = oe_low;
         rd_rises++;
      end
   end

   always @(negedge dbg_clk) begin
      if (rd_rises > 0 && !dd_oe && dbg_rst_n) rd_falls++;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_model();
      wr_shift = '0; wr_bits = 0; rd_rises = 0; rd_falls = 0;
      ent_rises = 0; low_cyc = 0; first_gap = -1;
   endtask

   task automatic pulse_start(input logic enter, input logic [2:0] len,
                              input logic [31:0] cmd);
      @(negedge clk);
      req_enter = enter; req_len = len; req_cmd = cmd; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_txn(input logic [2:0] len, input logic [31:0] cmd,
                          input logic [7:0] rsp, input bit full);
      bit seen;
      logic [31:0] exp_w;
      clear_model();
      tgt_rsp = rsp;
      pulse_start(1'b0, len, cmd);
      wait_done(seen);
      exp_w = '0;
      for (int b = 0; b < len; b++) exp_w = (exp_w << 8) | 32'(cmd[b*8 +: 8]);
      check(seen && busy == 1'b0, "R12 done seen with busy low", {31'd0, busy}, 0);
      check(rsp_byte == rsp, "R7 response byte", rsp_byte, rsp);
      if (full) begin
         check(wr_bits == len * 8, "R4 command bit count", wr_bits, len * 8);
         check(wr_shift == exp_w, "R4 command bit order", wr_shift, exp_w);
         check(rd_rises == 8, "R7 read edge count", rd_rises, 8);
         check(first_gap >= 2 * HALF, "R6 turnaround gap", first_gap, 2 * HALF);
         @(negedge clk);
         check(done == 1'b0, "R10 done single cycle", {31'd0, done}, 0);
         check(dd_oe == 1'b0, "R8 enable low after read", {31'd0, dd_oe}, 0);
      end
   endtask

   initial begin : watchdog
      while (cyc < 190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      bit seen;
      logic [7:0] held;
      int edges_before;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(dbg_rst_n && !dbg_clk && !dd_oe && !busy && !done && !req_reject,
            "R1 reset state", {26'd0, dbg_rst_n, dbg_clk, dd_oe, busy, done, req_reject},
            32'h20);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(dbg_rst_n && !dbg_clk && !dd_oe && !busy, "R1 idle after reset",
            {28'd0, dbg_rst_n, dbg_clk, dd_oe, busy}, 32'h8);

      // R2 / R3 debug entry
      clear_model();
      pulse_start(1'b1, 3'd0, 32'h0);
      check(busy == 1'b1, "R12 busy after accept", {31'd0, busy}, 1);
      wait_done(seen);
      check(seen, "R2 entry done", {31'd0, seen}, 1);
      check(ent_rises == 2, "R2 entry clock pulses", ent_rises, 2);
      check(wr_bits == 0 && rd_rises == 0, "R2 no data activity", wr_bits + rd_rises, 0);
      check(low_cyc == (HOLD + 4) * HALF, "R3 reset low span", low_cyc, (HOLD + 4) * HALF);
      @(negedge clk);
      check(dbg_rst_n == 1'b1, "R2 reset released", {31'd0, dbg_rst_n}, 1);
      check(rsp_byte == 8'h00, "R10 entry leaves response", rsp_byte, 0);

      // status query and the pointer/load examples
      run_txn(3'd1, 32'h0000_0034, 8'h81, 1'b1);
      run_txn(3'd4, 32'h3412_9056, 8'h5A, 1'b1);
      run_txn(3'd2, 32'h0000_E056, 8'hC7, 1'b1);

      // R4 all byte counts with several patterns
      for (int l = 1; l <= NB; l++) begin
         for (int p = 0; p < 6; p++) begin
            run_txn(3'(l), 32'hA5C3_0F96 ^ (32'(p) * 32'h1357_9BDF),
                    8'(p * 37 + l), 1'b1);
         end
      end

      // R7 every response value
      for (int v = 0; v < 256; v++) begin
         run_txn(3'd1, 32'(8'(~v)), 8'(v), v < 4);
      end

      // R5 data never moved while the clock was high
      check(dc_hi_changes == 0, "R5 data stable while clock high", dc_hi_changes, 0);

      // R10 response held afterwards
      held = rsp_byte;
      repeat (25) @(negedge clk);
      check(rsp_byte == held, "R10 response held", rsp_byte, held);

      // R11 invalid counts
      for (int l = 0; l < 8; l++) begin
         if (l >= 1 && l <= NB) continue;
         clear_model();
         edges_before = dc_hi_changes;
         @(negedge clk);
         req_enter = 1'b0; req_len = 3'(l); req_cmd = 32'hFFFF_FFFF; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
         check(req_reject == 1'b1 && busy == 1'b0, "R11 reject pulse",
               {30'd0, req_reject, busy}, 32'h2);
         repeat (20) @(negedge clk);
         check(wr_bits + rd_rises + ent_rises == 0 && dbg_rst_n && !dd_oe && !busy,
               "R11 no line activity", wr_bits + rd_rises + ent_rises, 0);
         check(rsp_byte == held, "R11 response unchanged", rsp_byte, held);
      end

      // R9 start while busy is ignored
      clear_model();
      tgt_rsp = 8'h3C;
      pulse_start(1'b0, 3'd2, 32'h0000_B7E1);
      repeat (30) @(negedge clk);
      req_enter = 1'b0; req_len = 3'd1; req_cmd = 32'h0000_0011; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      wait_done(seen);
      check(wr_bits == 16, "R9 count unchanged by late start", wr_bits, 16);
      check(wr_shift == 32'h0000_E1B7, "R9 command unchanged by late start",
            wr_shift, 32'h0000_E1B7);
      check(rsp_byte == 8'h3C, "R9 response of first request", rsp_byte, 8'h3C);
      repeat (5) @(negedge clk);
      check(busy == 1'b0 && wr_bits == 16, "R9 no second transaction",
            {31'd0, busy}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule